// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the control and status word of a floating-point unit. Software reads it through a read port and writes it through a write port. The arithmetic unit reports exceptions as single-cycle pulses, one line per exception class. The block keeps a sticky flag for each class. It also drives the current rounding mode, the denormal-input zeroing enable and the effective flush-to-zero enable back to the datapath.

Each exception class has its own mask bit. When a pulse arrives while its mask bit is clear, the block raises a one-cycle trap request for that class on the next cycle. A software write that sets any bit in the reserved upper half is refused: the register keeps its previous value and a fault pulse is raised.

Hardware flag setting always wins over a software write in the same cycle. The pulse is ORed into the written flag value, so an exception is never lost.

Top module: `fpcsr_top`

## Requirements
- R1: After reset the register reads 0x00001F80: all six masks set, all flags clear, round-to-nearest, both zeroing controls off.
- R2: The 16 implemented bits have this layout: bits 5:0 are the flags, bit 6 is the denormal-input zeroing enable, bits 12:7 are the masks in the same class order as the flags, bits 14:13 are the rounding field and bit 15 is the flush-to-zero enable. A legal write is read back exactly. `round_mode` shows bits 14:13, encoded 00 nearest, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R3: Each exception pulse sets its flag one cycle later. The flag and pulse order is bit 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision.
- R4: A set flag stays set through any number of cycles without a legal write. Only a legal write can clear it.
- R5: A write with any of bits 31:16 set makes `wr_fault` high for exactly the next cycle. The write changes no register bit.
- R6: When a legal write and an exception pulse occur in the same cycle, the flag becomes the written bit ORed with the pulse.
- R7: `trap_req[i]` is high for one cycle, the cycle after `exc_pulse[i]`, and only if mask bit i was clear when the pulse arrived. A masked pulse gives no trap request.
- R8: `rd_data` carries the zero-extended register while `rd_en` is high and is zero otherwise. Bits 31:16 are always read as zero.
- R9: `flush_zero_en` is high only when bit 15 and the underflow mask (bit 11) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_en | input | 1 | Software read strobe |
| rd_data | output | 32 | Register value while read is active, else zero |
| exc_pulse | input | 6 | Exception pulses from the arithmetic unit |
| round_mode | output | 2 | Current rounding field |
| daz_en | output | 1 | Denormal source operands treated as zero |
| flush_zero_en | output | 1 | Underflowing results forced to zero |
| exc_mask | output | 6 | Current mask bits |
| trap_req | output | 6 | One-cycle trap requests, one per class |
| wr_fault | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench writes a directed value in each rounding encoding to show that the fields land in their correct bit positions. It raises single exception pulses with all classes masked and then with all classes unmasked, which separates the flag-setting path from the trap path. Refused writes are issued while a pulse is present, to show that a fault blocks software but not hardware. A long random run mixes legal writes, reserved-bit writes, idle cycles and pulses. A bench model checks that run, which exposes any ordering mistake between a write and a flag set.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int REG_W     = 32;
  localparam int IMPL_W    = 16;
  localparam int NFLAG     = 6;
  localparam int DAZ_BIT   = 6;
  localparam int MASK_LSB  = 7;
  localparam int RC_LSB    = 13;
  localparam int RC_W      = 2;
  localparam int FTZ_BIT   = 15;
  localparam int UF_IDX    = 4;
  localparam int CTRL_W    = IMPL_W - NFLAG;
  localparam logic [REG_W-1:0] RESET_VAL = 32'h0000_1F80;

  // A write is refused when any unimplemented bit is nonzero.
  function automatic logic reserved_hit(input logic [REG_W-1:0] d);
    return |d[REG_W-1:IMPL_W];
  endfunction

  // Flag update: hardware pulses are always ORed in.
  function automatic logic flag_next(input logic cur, input logic load,
                                     input logic wbit, input logic pulse);
    return (load ? wbit : cur) | pulse;
  endfunction
endpackage

// File: rtl/fpcsr_write_check.sv
module fpcsr_write_check
  import fpcsr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         load_ok,
  output logic         wr_fault
);
  logic reject;

  assign reject  = wr_en & reserved_hit(wr_data);
  assign load_ok = wr_en & ~reject;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_fault <= 1'b0;
    else        wr_fault <= reject;
  end

  // R5
  fault_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> wr_fault);
  // R5
  fault_only_after_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reject |=> !wr_fault);
endmodule

// File: rtl/fpcsr_flag_bank.sv
module fpcsr_flag_bank
  import fpcsr_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ok,
  input  logic [N-1:0] load_flags,
  input  logic [N-1:0] exc_pulse,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_next(flag_q[i], load_ok, load_flags[i], exc_pulse[i]);
    end

    // R3
    pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse[i] |=> flag_q[i]);
    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !load_ok) |=> flag_q[i]);
  end
endmodule

// File: rtl/fpcsr_ctrl_bank.sv
module fpcsr_ctrl_bank
  import fpcsr_pkg::*;
#(
  parameter int                W     = CTRL_W,
  parameter logic [W-1:0]      RST_V = RESET_VAL[IMPL_W-1:NFLAG]
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ok,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= RST_V;
    else if (load_ok) ctrl_q <= load_val;
  end

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |=> $stable(ctrl_q));
endmodule

// File: rtl/fpcsr_trap_gen.sv
module fpcsr_trap_gen
  import fpcsr_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] exc_pulse,
  input  logic [N-1:0] mask,
  output logic [N-1:0] trap_req
);
  logic [N-1:0] trap_evt;
  assign trap_evt = exc_pulse & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) trap_req <= '0;
    else        trap_req <= trap_evt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_pulse[i] && !mask[i]) |=> trap_req[i]);
    // R7
    trap_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_pulse[i] || mask[i]) |=> !trap_req[i]);
  end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NFLAG-1:0]  exc_pulse,
  output logic [RC_W-1:0]   round_mode,
  output logic              daz_en,
  output logic              flush_zero_en,
  output logic [NFLAG-1:0]  exc_mask,
  output logic [NFLAG-1:0]  trap_req,
  output logic              wr_fault
);
  logic              load_ok;
  logic [NFLAG-1:0]  flag_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IMPL_W-1:0] csr_word;

  fpcsr_write_check #(.W(REG_W)) u_wchk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .load_ok(load_ok), .wr_fault(wr_fault)
  );

  fpcsr_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok),
    .load_flags(wr_data[NFLAG-1:0]), .exc_pulse(exc_pulse), .flag_q(flag_q)
  );

  fpcsr_ctrl_bank #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok),
    .load_val(wr_data[IMPL_W-1:NFLAG]), .ctrl_q(ctrl_q)
  );

  assign csr_word      = {ctrl_q, flag_q};
  assign exc_mask      = csr_word[MASK_LSB +: NFLAG];
  assign round_mode    = csr_word[RC_LSB +: RC_W];
  assign daz_en        = csr_word[DAZ_BIT];
  assign flush_zero_en = csr_word[FTZ_BIT] & exc_mask[UF_IDX];
  assign rd_data       = rd_en ? {{(REG_W-IMPL_W){1'b0}}, csr_word} : '0;

  fpcsr_trap_gen #(.N(NFLAG)) u_trap (
    .clk(clk), .rst_n(rst_n), .exc_pulse(exc_pulse), .mask(exc_mask),
    .trap_req(trap_req)
  );

  // R6
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && exc_pulse[0]) |=> flag_q[0]);
endmodule

// File: tb/fpcsr_top_tb_top.sv
`timescale 1ns/1ps
module fpcsr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [5:0]  exc_pulse = '0;
  logic [1:0]  round_mode;
  logic        daz_en, flush_zero_en, wr_fault;
  logic [5:0]  exc_mask, trap_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpcsr_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .exc_pulse(exc_pulse),
    .round_mode(round_mode), .daz_en(daz_en), .flush_zero_en(flush_zero_en),
    .exc_mask(exc_mask), .trap_req(trap_req), .wr_fault(wr_fault)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Bench model of the next register value.
  function automatic logic [15:0] model_next(input logic [15:0] cur, input logic we,
                                             input logic [31:0] wd, input logic [5:0] exc);
    logic [15:0] n;
    n = cur;
    if (we && wd[31:16] == 16'h0) n = wd[15:0];
    n[5:0] = n[5:0] | exc;
    return n;
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    logic [31:0] wd;
    logic [5:0]  ex;
    logic        we, exp_fault;
    logic [5:0]  exp_trap;
    void'($urandom(32'd1234));
    rd_en = 1'b1;
    tick(); tick();
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 reset word", rd_data, 32'h0000_1F80);
    chk("R1 masks", {26'd0, exc_mask}, 32'h3F);
    chk("R1 rounding", {30'd0, round_mode}, 0);
    chk("R1 daz/fault/trap", {24'd0, daz_en, wr_fault, trap_req}, 0);

    // R2 each rounding encoding and field readback
    for (int rc = 0; rc < 4; rc++) begin
      wd = (32'(rc) << 13) | 32'h0000_8041;
      wr(wd);
      chk("R2 readback", rd_data, wd);
      chk("R2 round_mode", {30'd0, round_mode}, 32'(rc));
      chk("R2 daz bit6", {31'd0, daz_en}, 1);
    end

    // R3 masked pulse sets flag, R7 no trap
    wr(32'h0000_1F80);
    exc_pulse = 6'b000100; tick(); exc_pulse = '0;
    chk("R3 divzero flag", rd_data, 32'h0000_1F84);
    chk("R7 masked no trap", {26'd0, trap_req}, 0);

    // R4 sticky over idle cycles
    for (int k = 0; k < 5; k++) tick();
    chk("R4 sticky", rd_data, 32'h0000_1F84);

    // R5 refused write while a pulse is present
    wr_en = 1'b1; wr_data = 32'h0001_0000; exc_pulse = 6'b100000; tick();
    wr_en = 1'b0; wr_data = '0; exc_pulse = '0;
    chk("R5 fault pulse", {31'd0, wr_fault}, 1);
    chk("R5 unchanged plus hw flag", rd_data, 32'h0000_1FA4);
    tick();
    chk("R5 fault one cycle", {31'd0, wr_fault}, 0);

    // R4 legal write clears flags
    wr(32'h0000_1F80);
    chk("R4 clear by write", rd_data, 32'h0000_1F80);

    // R6 same-cycle write and pulse
    wr_en = 1'b1; wr_data = 32'h0000_0000; exc_pulse = 6'b001000; tick();
    wr_en = 1'b0; exc_pulse = '0;
    chk("R6 merge", rd_data, 32'h0000_0008);

    // R7 unmasked trap (masks are now clear)
    exc_pulse = 6'b010001; tick(); exc_pulse = '0;
    chk("R7 trap raised", {26'd0, trap_req}, 32'h11);
    tick();
    chk("R7 trap one cycle", {26'd0, trap_req}, 0);

    // R8 read gating
    rd_en = 1'b0; #1;
    chk("R8 read idle zero", rd_data, 0);
    rd_en = 1'b1; #1;

    // R9 flush enable
    wr(32'h0000_8800);
    chk("R9 ftz with uf mask", {31'd0, flush_zero_en}, 1);
    wr(32'h0000_8000);
    chk("R9 ftz without uf mask", {31'd0, flush_zero_en}, 0);

    // Random run against the bench model
    model = 16'h8000;
    for (int n = 0; n < 500; n++) begin
      we = ($urandom % 4) == 0;
      wd = {(($urandom % 5) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0, 16'($urandom)};
      ex = (($urandom % 3) == 0) ? 6'($urandom) : 6'h0;
      rd_en = ($urandom % 8) != 0;
      exp_fault = we && wd[31:16] != 16'h0;
      exp_trap  = ex & ~model[12:7];
      wr_en = we; wr_data = wd; exc_pulse = ex;
      tick();
      model = model_next(model, we, wd, ex);
      chk("R3/R4/R6 random readback", rd_data, rd_en ? {16'h0, model} : 32'h0);
      chk("R7 random trap", {26'd0, trap_req}, {26'd0, exp_trap});
      chk("R5 random fault", {31'd0, wr_fault}, {31'd0, exp_fault});
      chk("R2 random round", {30'd0, round_mode}, {30'd0, model[14:13]});
      chk("R9 random ftz", {31'd0, flush_zero_en}, {31'd0, model[15] & model[11]});
    end
    wr_en = 1'b0; exc_pulse = '0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule